// File: doc/BRIEF.md
# 4x4 Hybrid Inverse Transform Reconstructor

This block rebuilds a 4x4 tile of 8-bit pixels from a tile of signed 16-bit transform coefficients and a tile of 8-bit prediction pixels. A 2-bit type selects which one-dimensional inverse transform is used in each of two separable passes. The choices are a four-point inverse cosine transform (DCT) and a four-point inverse asymmetric sine transform (ADST). The first pass runs along the rows of the coefficient tile. The second pass runs along the columns of the first pass's result. The column results are rounded down by a factor of 16, added to the prediction and clipped to the 8-bit unsigned range.

A client presents the whole tile with a one-cycle `start`. It then waits for the one-cycle `done` pulse and reads the 16 pixels, which stay held until the next tile completes. One shared 1-D datapath handles one row or one column per cycle. A tile therefore takes eight processing cycles after it is accepted.

Top module: `iht4_recon`

## Requirements
- R1: A `start` with type 1, 2 or 3, seen while `busy` is low, is accepted: `busy` is high in the next cycle. A `start` seen while `busy` is high is ignored, and the result belongs to the tile that was accepted.
- R2: A `start` with type 0 is ignored. `busy` stays low, no `done` pulse follows, and `pix_out` keeps its value.
- R3: The first pass transforms each row (the four coefficients of equal row index). The second pass transforms each column of the first-pass result. Coefficient (r,c) sits at `coef_in[16*(4r+c) +: 16]`, prediction and output pixel (r,c) at bits `[8*(4r+c) +: 8]`.
- R4: Type 1 uses the inverse DCT for the row pass and the inverse ADST for the column pass.
- R5: Type 2 uses the inverse ADST for the row pass and the inverse DCT for the column pass.
- R6: Type 3 uses the inverse ADST for both passes.
- R7: The inverse DCT of (x0..x3) works as follows. a=x0+x2 and b=x0-x2 wrap to 16 bits. Then s0=N(11585a), s1=N(11585b), s2=N(6270x1-15137x3), s3=N(15137x1+6270x3). The outputs, each wrapped to 16 bits, are (s0+s3, s1+s2, s1-s2, s0-s3).
- R8: The inverse ADST of (x0..x3) works as follows, with 32-bit two's-complement sums. p=5283x0+15212x2+9929x3, q=9929x0-5283x2-15212x3, u=13377(x0-x2+x3), v=13377x1. The outputs are (N(p+v), N(q+v), N(u), N(p+q-v)).
- R9: N(t) is (t+8192) shifted arithmetically right by 14, evaluated without overflow, then saturated to -32768..32767.
- R10: Each output pixel is computed from the column-pass value y as follows. Take (y+8) arithmetically shifted right by 4, add the prediction pixel at the same position, and clip the sum to 0..255.
- R11: Count the edge that accepts `start` as edge 0. `done` is high for exactly the one cycle after edge 8, `busy` falls in that same cycle, and the new pixels are valid from then on.
- R12: After reset, `busy` and `done` are low and `pix_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to process the presented tile |
| tx_type | input | 2 | Transform pair select, 1 to 3 |
| coef_in | input | 256 | Sixteen signed 16-bit coefficients, raster order |
| pred_in | input | 128 | Sixteen unsigned prediction pixels, raster order |
| busy | output | 1 | A tile is in progress |
| done | output | 1 | One-cycle pulse: `pix_out` holds a new tile |
| pix_out | output | 128 | Sixteen reconstructed pixels, raster order |

## Verification
The bench raises `start` half a cycle before an edge. It checks `busy` half a cycle after that accepting edge. It checks that `done` is still low half a cycle after edge 7. It checks that `done` is high, `busy` is low and all sixteen pixels match a bit-exact integer model half a cycle after edge 8. It checks that `done` is low again one cycle later. For requests that must be ignored, the outputs are sampled for twelve cycles at mid-cycle, away from every edge.

// File: rtl/iht4_recon.sv
module iht4_recon (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   tx_type,
  input  logic [255:0] coef_in,
  input  logic [127:0] pred_in,
  output logic         busy,
  output logic         done,
  output logic [127:0] pix_out
);
  localparam int N  = 4;
  localparam int CW = 16;
  localparam int PW = 8;

  typedef enum logic [1:0] {S_IDLE, S_ROW, S_COL} st_t;

  st_t                 st;
  logic [1:0]          cnt;
  logic [1:0]          typ;
  logic signed [CW-1:0] cf [N*N];
  logic signed [CW-1:0] tb [N*N];
  logic [PW-1:0]        pr [N*N];
  logic signed [CW-1:0] xin  [N];
  logic signed [CW-1:0] yout [N];
  logic                 use_dct;

  function automatic logic signed [15:0] rnd14(input logic signed [31:0] v);
    logic signed [32:0] t;
    t = {v[31], v};
    t = (t + 33'sd8192) >>> 14;
    if (t > 33'sd32767)       return 16'sh7fff;
    else if (t < -33'sd32768) return 16'sh8000;
    else                      return t[15:0];
  endfunction

  function automatic logic [7:0] recon(input logic signed [15:0] y, input logic [7:0] p);
    logic signed [16:0] r;
    logic signed [17:0] s;
    r = {y[15], y};
    r = (r + 17'sd8) >>> 4;
    s = {r[16], r} + {10'd0, p};
    if (s < 0)                 return 8'h00;
    else if (s > 18'sd255)     return 8'hff;
    else                       return s[7:0];
  endfunction

  assign busy    = (st != S_IDLE);
  assign use_dct = (st == S_ROW) ? (typ == 2'd1) : (typ == 2'd2);

  always_comb begin
    logic signed [15:0] a, b, s0, s1, s2, s3;
    logic signed [31:0] e0, e1, e2, e3, ea, eb, zp, zq, zu, zv;
    for (int k = 0; k < N; k++)
      xin[k] = (st == S_COL) ? tb[N*k + int'(cnt)] : cf[N*int'(cnt) + k];
    e0 = xin[0]; e1 = xin[1]; e2 = xin[2]; e3 = xin[3];
    a = xin[0] + xin[2];
    b = xin[0] - xin[2];
    ea = a; eb = b;
    s0 = rnd14(ea * 32'sd11585);
    s1 = rnd14(eb * 32'sd11585);
    s2 = rnd14(e1 * 32'sd6270 - e3 * 32'sd15137);
    s3 = rnd14(e1 * 32'sd15137 + e3 * 32'sd6270);
    zp = e0 * 32'sd5283 + e2 * 32'sd15212 + e3 * 32'sd9929;
    zq = e0 * 32'sd9929 - e2 * 32'sd5283 - e3 * 32'sd15212;
    zu = (e0 - e2 + e3) * 32'sd13377;
    zv = e1 * 32'sd13377;
    if (use_dct) begin
      yout[0] = s0 + s3;
      yout[1] = s1 + s2;
      yout[2] = s1 - s2;
      yout[3] = s0 - s3;
    end else begin
      yout[0] = rnd14(zp + zv);
      yout[1] = rnd14(zq + zv);
      yout[2] = rnd14(zu);
      yout[3] = rnd14(zp + zq - zv);
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_IDLE && start) begin
      for (int i = 0; i < N*N; i++) begin
        cf[i] <= coef_in[CW*i +: CW];
        pr[i] <= pred_in[PW*i +: PW];
      end
    end
    if (st == S_ROW)
      for (int k = 0; k < N; k++) tb[N*int'(cnt) + k] <= yout[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= 2'd0;
      typ     <= 2'd0;
      done    <= 1'b0;
      pix_out <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start && tx_type != 2'd0) begin
          typ <= tx_type;
          cnt <= 2'd0;
          st  <= S_ROW;
        end
        S_ROW: begin
          cnt <= cnt + 2'd1;
          if (cnt == 2'd3) st <= S_COL;
        end
        S_COL: begin
          for (int k = 0; k < N; k++)
            pix_out[PW*(N*k + int'(cnt)) +: PW] <= recon(yout[k], pr[N*k + int'(cnt)]);
          cnt <= cnt + 2'd1;
          if (cnt == 2'd3) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && tx_type != 2'd0) |=> busy); // R1
  AST_TYPE0_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && tx_type == 2'd0) |=> !busy); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R11
  AST_PIX_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(pix_out)); // R11
endmodule

// File: tb/iht4_recon_tb.sv
module iht4_recon_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] tx_type = 2'd0;
  logic [255:0] coef_in = '0;
  logic [127:0] pred_in = '0;
  logic busy, done;
  logic [127:0] pix_out;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  int cin [16];
  int pin [16];
  int unsigned seed = 32'd12345;

  iht4_recon u_dut (.clk(clk), .rst_n(rst_n), .start(start), .tx_type(tx_type),
    .coef_in(coef_in), .pred_in(pred_in), .busy(busy), .done(done), .pix_out(pix_out));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int w16(input int v);
    return int'(shortint'(v));
  endfunction

  function automatic int nrm(input int v);
    longint t;
    t = (longint'(v) + 64'sd8192) >>> 14;
    if (t > 32767) return 32767;
    if (t < -32768) return -32768;
    return int'(t);
  endfunction

  function automatic void dct4(input int x [4], output int y [4]);
    int a, b, s0, s1, s2, s3;
    a = w16(x[0] + x[2]);
    b = w16(x[0] - x[2]);
    s0 = nrm(a * 11585);
    s1 = nrm(b * 11585);
    s2 = nrm(x[1] * 6270 - x[3] * 15137);
    s3 = nrm(x[1] * 15137 + x[3] * 6270);
    y[0] = w16(s0 + s3); y[1] = w16(s1 + s2);
    y[2] = w16(s1 - s2); y[3] = w16(s0 - s3);
  endfunction

  function automatic void adst4(input int x [4], output int y [4]);
    int p, q, u, v;
    p = 5283 * x[0] + 15212 * x[2] + 9929 * x[3];
    q = 9929 * x[0] - 5283 * x[2] - 15212 * x[3];
    u = 13377 * (x[0] - x[2] + x[3]);
    v = 13377 * x[1];
    y[0] = nrm(p + v); y[1] = nrm(q + v);
    y[2] = nrm(u);     y[3] = nrm(p + q - v);
  endfunction

  function automatic void model(input int ty, output int px [16]);
    int tmp [16];
    int xv [4];
    int yv [4];
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 4; k++) xv[k] = cin[4*r + k];
      if (ty == 1) dct4(xv, yv); else adst4(xv, yv);
      for (int k = 0; k < 4; k++) tmp[4*r + k] = yv[k];
    end
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 4; k++) xv[k] = tmp[4*k + c];
      if (ty == 2) dct4(xv, yv); else adst4(xv, yv);
      for (int m = 0; m < 4; m++) begin
        int s;
        s = ((yv[m] + 8) >>> 4) + pin[4*m + c];
        px[4*m + c] = (s < 0) ? 0 : (s > 255) ? 255 : s;
      end
    end
  endfunction

  task automatic load();
    for (int i = 0; i < 16; i++) begin
      coef_in[16*i +: 16] = 16'(cin[i]);
      pred_in[8*i +: 8]   = 8'(pin[i]);
    end
  endtask

  function automatic int rnd_val(input int span);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % 32'(2*span)) - span;
  endfunction

  // Accept at edge 0, done due after edge 8; poke drives a rival start mid-run.
  task automatic run_case(input int ty, input string req, input bit poke);
    int px [16];
    model(ty, px);
    load();
    tx_type = 2'(ty);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy == 1'b1, "R1 busy after accept", int'(busy), 1);
    repeat (2) @(negedge clk);
    if (poke) begin
      coef_in = ~coef_in;
      pred_in = ~pred_in;
      tx_type = (ty == 3) ? 2'd1 : 2'd3;
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (4) @(negedge clk);
    end else
      repeat (5) @(negedge clk);
    chk(done == 1'b0, "R11 done early", int'(done), 0);
    @(negedge clk);
    chk(done == 1'b1, "R11 done due", int'(done), 1);
    chk(busy == 1'b0, "R11 busy falls", int'(busy), 0);
    for (int i = 0; i < 16; i++)
      chk(int'(pix_out[8*i +: 8]) == px[i], req, int'(pix_out[8*i +: 8]), px[i]);
    @(negedge clk);
    chk(done == 1'b0, "R11 done single", int'(done), 0);
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R12 busy", int'(busy), 0);
    chk(done == 1'b0, "R12 done", int'(done), 0);
    chk(pix_out == '0, "R12 pix", int'(pix_out[31:0]), 0);
  endtask

  task automatic t_dc(input int ty, input string req);
    for (int i = 0; i < 16; i++) begin cin[i] = 0; pin[i] = 100 + i; end
    cin[0] = 200;
    run_case(ty, req, 1'b0);
  endtask

  task automatic t_orient(input int ty, input string req);
    for (int i = 0; i < 16; i++) begin cin[i] = 0; pin[i] = 128; end
    cin[1] = 300;
    run_case(ty, req, 1'b0);
    cin[1] = 0; cin[4] = 300;
    run_case(ty, req, 1'b0);
  endtask

  task automatic t_random(input int ty, input string req);
    for (int i = 0; i < 16; i++) begin cin[i] = rnd_val(512); pin[i] = rnd_val(128) + 128; end
    run_case(ty, req, 1'b0);
  endtask

  task automatic t_sat();
    for (int i = 0; i < 16; i++) begin cin[i] = 32767; pin[i] = 60; end
    run_case(3, "R9 saturate high", 1'b0);
    for (int i = 0; i < 16; i++) cin[i] = -32768;
    run_case(3, "R9 saturate low", 1'b0);
  endtask

  task automatic t_clip();
    for (int i = 0; i < 16; i++) begin cin[i] = 0; pin[i] = 250; end
    cin[0] = 2000;
    run_case(1, "R10 clip high", 1'b0);
    for (int i = 0; i < 16; i++) pin[i] = 5;
    cin[0] = -2000;
    run_case(2, "R10 clip low", 1'b0);
  endtask

  task automatic t_type0();
    logic [127:0] held;
    int seen_busy = 0;
    int seen_done = 0;
    held = pix_out;
    for (int i = 0; i < 16; i++) begin cin[i] = 999; pin[i] = 7; end
    load();
    tx_type = 2'd0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int n = 0; n < 12; n++) begin
      if (busy) seen_busy++;
      if (done) seen_done++;
      @(negedge clk);
    end
    chk(seen_busy == 0, "R2 busy", seen_busy, 0);
    chk(seen_done == 0, "R2 done", seen_done, 0);
    chk(pix_out == held, "R2 pix held", int'(pix_out[31:0]), int'(held[31:0]));
  endtask

  task automatic t_busy_start();
    for (int i = 0; i < 16; i++) begin cin[i] = rnd_val(400); pin[i] = rnd_val(100) + 128; end
    run_case(2, "R1 start while busy ignored", 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_dc(1, "R4 dc");
    t_dc(2, "R5 dc");
    t_dc(3, "R6 dc");
    t_orient(1, "R3 orientation dct rows");
    t_orient(2, "R3 orientation adst rows");
    for (int n = 0; n < 3; n++) begin
      t_random(1, "R7 R8 random type1");
      t_random(2, "R7 R8 random type2");
      t_random(3, "R8 random type3");
    end
    t_sat();
    t_clip();
    t_type0();
    t_busy_start();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule